// File: doc/BRIEF.md
# Programmable Auxiliary Clock Divider

This block drives a single auxiliary output pin that carries one of three things: the master clock divided by a programmable integer, a straight copy of the oscillator input clock, or a lock indicator for an external PLL. A 6-bit ratio field chooses between division and pass-through. Ratios 2 to 63 divide. Ratios 0 and 1 select the oscillator copy. A separate mode input repurposes the pin as an active-low lock status flag. The PLL is not modelled here; its lock state arrives as an input.

The divider is a three-state machine in the master clock domain. PARK means the divider is idle and the pin shows the oscillator clock. HIGH is the high phase of a divided period and LOW is the low phase. The transitions are:
- PARK→HIGH when the ratio is 2 or more.
- HIGH→LOW when the high count runs out.
- LOW→HIGH when the low count runs out and the ratio is 2 or more.
- LOW→PARK when the low count runs out and the ratio is below 2.

A ratio is captured only on entry to HIGH, which is a rising edge of the output. A change of ratio therefore never cuts a phase short.

Top module: `aux_refclk_gen`

## Requirements
- R1: With `ratio` (unsigned binary) between 2 and 63 and `lock_mode` = 0, each output period lasts exactly `ratio` master clock cycles.
- R2: For an even ratio R, the output is high for R/2 and low for R/2 master cycles.
- R3: With `ratio` = 0 and `lock_mode` = 0, once the divider is parked, `aux_out` equals `osc_clk` combinationally.
- R4: `ratio` = 1 behaves as bypass, exactly like `ratio` = 0.
- R5: With `lock_mode` = 1, `aux_out` is the inverse of `pll_locked` (low means locked), whatever the ratio.
- R6: For an odd ratio R, the output is high for (R-1)/2 and low for (R+1)/2 master cycles.
- R7: A new ratio is captured only at an output rising edge. The phases in progress complete at the old length, so no runt pulse appears.
- R8: Changing to a bypass ratio while dividing lets the current low phase finish, then parks the divider so the output follows `osc_clk`.
- R9: While `rst_n` is low and after reset, the divider is parked and `aux_out` follows `osc_clk` (when `lock_mode` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; the divider runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the divider |
| osc_clk | input | 1 | Oscillator clock passed through in bypass |
| ratio | input | 6 | Divide ratio; 0 and 1 select bypass |
| lock_mode | input | 1 | 1 turns the pin into a lock flag |
| pll_locked | input | 1 | 1 when the external PLL is locked |
| aux_out | output | 1 | Auxiliary clock or active-low lock flag |

## Verification
The bypass and lock-flag paths are combinational, so the bench checks them 1 ns after it changes `osc_clk`, `pll_locked` or `lock_mode`. The divided clock is registered. Its state changes on a rising `mclk` edge and is sampled on the following falling edge, so each sample stands for one master cycle. A ratio written on a falling edge is first seen by the divider on the next rising edge, but it only takes effect at the next output rise. The bench therefore measures high and low runs only after it has seen such a rise. For the mid-period changes, it counts the samples still due in the current phase before it looks for the new period lengths.

// File: rtl/aux_clk_pkg.sv
package aux_clk_pkg;

    // Divider state machine encoding
    typedef enum logic [1:0] {
        DIV_PARK = 2'd0,
        DIV_HIGH = 2'd1,
        DIV_LOW  = 2'd2
    } div_state_e;

    // Smallest ratio that actually divides; anything below selects bypass
    localparam int unsigned MIN_DIV = 2;

endpackage

// File: rtl/aux_phase_len.sv
// Splits a ratio into high and low phase lengths (high = floor(R/2)).
module aux_phase_len #(
    parameter int RW = 6
) (
    input  logic [RW-1:0] ratio_in,
    output logic [RW-1:0] hi_len,
    output logic [RW-1:0] lo_len
);
    always_comb begin
        hi_len = ratio_in >> 1;
        lo_len = ratio_in - (ratio_in >> 1);
    end
endmodule

// File: rtl/aux_div_fsm.sv
module aux_div_fsm
    import aux_clk_pkg::*;
#(
    parameter int RW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] ratio_in,
    output logic          div_hi,
    output logic          div_parked,
    output logic [RW-1:0] act_ratio
);
    localparam logic [RW-1:0] MIN_R = RW'(MIN_DIV);
    localparam logic [RW-1:0] ONE   = RW'(1);

    div_state_e    state_q, state_d;
    logic [RW-1:0] cnt_q, cnt_d;
    logic [RW-1:0] act_d;
    logic [RW-1:0] new_hi, new_lo_unused;
    logic [RW-1:0] act_hi_unused, act_lo;
    logic          new_ok;

    aux_phase_len #(.RW(RW)) u_len_new (
        .ratio_in (ratio_in),
        .hi_len   (new_hi),
        .lo_len   (new_lo_unused)
    );

    aux_phase_len #(.RW(RW)) u_len_act (
        .ratio_in (act_ratio),
        .hi_len   (act_hi_unused),
        .lo_len   (act_lo)
    );

    assign new_ok = (ratio_in >= MIN_R);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= DIV_PARK;
            cnt_q     <= '0;
            act_ratio <= '0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            act_ratio <= act_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        act_d   = act_ratio;
        unique case (state_q)
            DIV_PARK: begin
                if (new_ok) begin
                    state_d = DIV_HIGH;
                    cnt_d   = new_hi - ONE;
                    act_d   = ratio_in;
                end
            end
            DIV_HIGH: begin
                if (cnt_q == '0) begin
                    state_d = DIV_LOW;
                    cnt_d   = act_lo - ONE;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            DIV_LOW: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - ONE;
                end else if (new_ok) begin
                    state_d = DIV_HIGH;
                    cnt_d   = new_hi - ONE;
                    act_d   = ratio_in;
                end else begin
                    state_d = DIV_PARK;
                    cnt_d   = '0;
                    act_d   = '0;
                end
            end
            default: begin
                state_d = DIV_PARK;
                cnt_d   = '0;
                act_d   = '0;
            end
        endcase
    end

    // Outputs decoded from the registered state only
    always_comb begin
        div_hi     = (state_q == DIV_HIGH);
        div_parked = (state_q == DIV_PARK);
    end
endmodule

// File: rtl/aux_out_sel.sv
// Final pin selection: lock flag, oscillator copy or divided clock.
module aux_out_sel (
    input  logic lock_mode,
    input  logic pll_locked,
    input  logic div_parked,
    input  logic osc_clk,
    input  logic div_hi,
    output logic pin_out
);
    always_comb begin
        if (lock_mode)
            pin_out = ~pll_locked;
        else if (div_parked)
            pin_out = osc_clk;
        else
            pin_out = div_hi;
    end
endmodule

// File: rtl/aux_refclk_gen.sv
module aux_refclk_gen #(
    parameter int RW = 6
) (
    input  logic          mclk,
    input  logic          rst_n,
    input  logic          osc_clk,
    input  logic [RW-1:0] ratio,
    input  logic          lock_mode,
    input  logic          pll_locked,
    output logic          aux_out
);
    logic          div_hi;
    logic          div_parked;
    logic [RW-1:0] act_ratio;

    aux_div_fsm #(.RW(RW)) u_fsm (
        .clk        (mclk),
        .rst_n      (rst_n),
        .ratio_in   (ratio),
        .div_hi     (div_hi),
        .div_parked (div_parked),
        .act_ratio  (act_ratio)
    );

    aux_out_sel u_sel (
        .lock_mode  (lock_mode),
        .pll_locked (pll_locked),
        .div_parked (div_parked),
        .osc_clk    (osc_clk),
        .div_hi     (div_hi),
        .pin_out    (aux_out)
    );
endmodule

// File: rtl/aux_refclk_gen_chk.sv
module aux_refclk_gen_chk #(
    parameter int RW = 6
) (
    input logic          mclk,
    input logic          rst_n,
    input logic          osc_clk,
    input logic [RW-1:0] ratio,
    input logic          lock_mode,
    input logic          pll_locked,
    input logic          aux_out,
    input logic          div_hi,
    input logic          div_parked,
    input logic [RW-1:0] act_ratio
);
    localparam int CW = RW + 2;

    logic [CW-1:0] run_q;
    logic          hi_q;

    // Length of the current run of equal div_hi samples
    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
            hi_q  <= 1'b0;
        end else begin
            hi_q  <= div_hi;
            if (div_hi != hi_q)
                run_q <= CW'(1);
            else if (run_q != {CW{1'b1}})
                run_q <= run_q + CW'(1);
        end
    end

    assert_hi_len_R6: assert property (@(posedge mclk) disable iff (!rst_n)
        $fell(div_hi) |-> (run_q == CW'(act_ratio >> 1)));

    assert_lo_len_R1: assert property (@(posedge mclk) disable iff (!rst_n)
        ($rose(div_hi) && !$past(div_parked)) |->
        (run_q == CW'($past(act_ratio) - ($past(act_ratio) >> 1))));

    assert_ratio_hold_R7: assert property (@(posedge mclk) disable iff (!rst_n)
        (act_ratio != $past(act_ratio)) |-> ($rose(div_hi) || div_parked));

    assert_lock_flag_R5: assert property (@(posedge mclk) disable iff (!rst_n)
        lock_mode |-> (aux_out == !pll_locked));

    assert_bypass_R3: assert property (@(posedge mclk) disable iff (!rst_n)
        (div_parked && !lock_mode) |-> (aux_out == osc_clk));

    assert_stay_parked_R4: assert property (@(posedge mclk) disable iff (!rst_n)
        (div_parked && (ratio < RW'(2))) |=> div_parked);
endmodule

bind aux_refclk_gen aux_refclk_gen_chk #(.RW(RW)) u_chk (
    .mclk       (mclk),
    .rst_n      (rst_n),
    .osc_clk    (osc_clk),
    .ratio      (ratio),
    .lock_mode  (lock_mode),
    .pll_locked (pll_locked),
    .aux_out    (aux_out),
    .div_hi     (div_hi),
    .div_parked (div_parked),
    .act_ratio  (act_ratio)
);

// File: tb/aux_refclk_gen_bench.sv
`timescale 1ns/1ps
module aux_refclk_gen_bench;
    logic       mclk = 1'b0;
    logic       rst_n;
    logic       osc_clk;
    logic [5:0] ratio;
    logic       lock_mode;
    logic       pll_locked;
    logic       aux_out;
    logic       s;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 mclk = ~mclk;

    aux_refclk_gen u_aux_refclk_gen (
        .mclk       (mclk),
        .rst_n      (rst_n),
        .osc_clk    (osc_clk),
        .ratio      (ratio),
        .lock_mode  (lock_mode),
        .pll_locked (pll_locked),
        .aux_out    (aux_out)
    );

    // {ratio, expected high samples, expected low samples}
    localparam int NV = 9;
    localparam logic [17:0] VEC [NV] = '{
        {6'd2,  6'd1,  6'd1},
        {6'd3,  6'd1,  6'd2},
        {6'd4,  6'd2,  6'd2},
        {6'd5,  6'd2,  6'd3},
        {6'd7,  6'd3,  6'd4},
        {6'd10, 6'd5,  6'd5},
        {6'd63, 6'd31, 6'd32},
        {6'd62, 6'd31, 6'd31},
        {6'd6,  6'd3,  6'd3}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic sample();
        @(negedge mclk);
        s = aux_out;
    endtask

    // Count further samples equal to v; consumes the first differing sample
    task automatic run_len(input logic v, output int n);
        n = 0;
        for (int g = 0; g < 300; g++) begin
            sample();
            if (s != v) return;
            n++;
        end
    endtask

    // Wait for an output rise, then measure the following high and low runs
    task automatic measure(output int hi, output int lo);
        logic prev;
        int   k;
        prev = s;
        for (int g = 0; g < 300; g++) begin
            sample();
            if (!prev && s) break;
            prev = s;
        end
        run_len(1'b1, k); hi = k + 1;
        run_len(1'b0, k); lo = k + 1;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int hi, lo, n, m;
        rst_n = 1'b0; ratio = 6'd0; lock_mode = 1'b0; pll_locked = 1'b0;
        osc_clk = 1'b0; s = 1'b0;

        // R9: during reset the pin follows the oscillator
        repeat (2) @(negedge mclk);
        osc_clk = 1'b1; #1; check("R9 reset osc high", aux_out, 1);
        osc_clk = 1'b0; #1; check("R9 reset osc low", aux_out, 0);
        @(negedge mclk); rst_n = 1'b1;
        repeat (3) @(negedge mclk);

        // R3: ratio 0 passes the oscillator through
        osc_clk = 1'b1; #1; check("R3 bypass high", aux_out, 1);
        osc_clk = 1'b0; #1; check("R3 bypass low", aux_out, 0);

        // R4: ratio 1 is bypass too
        ratio = 6'd1;
        repeat (4) @(negedge mclk);
        osc_clk = 1'b1; #1; check("R4 ratio1 high", aux_out, 1);
        osc_clk = 1'b0; #1; check("R4 ratio1 low", aux_out, 0);

        // Vector loop: R1 period, R2 even duty, R6 odd duty
        for (int i = 0; i < NV; i++) begin
            @(negedge mclk);
            s = aux_out;
            ratio = VEC[i][17:12];
            measure(hi, lo);
            check((VEC[i][12] == 1'b0) ? "R2 high length" : "R6 high length",
                  hi, int'(VEC[i][11:6]));
            check((VEC[i][12] == 1'b0) ? "R2 low length" : "R6 low length",
                  lo, int'(VEC[i][5:0]));
            check("R1 period", hi + lo, int'(VEC[i][17:12]));
        end

        // R7: ratio change mid-high lets the old period complete
        ratio = 6'd10;
        measure(hi, lo);
        measure(hi, lo);          // now at first high sample of a 10-period
        sample();                 // second high sample
        ratio = 6'd2;
        run_len(1'b1, n);
        check("R7 remaining high", n + 2, 5);
        run_len(1'b0, m);
        check("R7 old low length", m + 1, 5);
        measure(hi, lo);
        check("R7 new high", hi, 1);
        check("R7 new low", lo, 1);

        // R8: switching to bypass finishes the low phase, then parks
        ratio = 6'd6;
        measure(hi, lo);
        measure(hi, lo);          // at first high sample of a 6-period
        osc_clk = 1'b1;
        ratio = 6'd0;
        run_len(1'b1, n);
        check("R8 high finishes", n + 1, 3);
        run_len(1'b0, m);
        check("R8 low finishes", m + 1, 3);
        check("R8 parked follows osc", s, 1);
        repeat (3) sample();
        check("R8 stays on osc", s, 1);
        osc_clk = 1'b0; #1; check("R8 osc low", aux_out, 0);

        // R5: lock indicator, independent of ratio
        ratio = 6'd5;
        lock_mode = 1'b1; pll_locked = 1'b0; #1;
        check("R5 unlocked high", aux_out, 1);
        pll_locked = 1'b1; #1;
        check("R5 locked low", aux_out, 0);
        n = 0;
        for (int g = 0; g < 12; g++) begin
            sample();
            if (s) n++;
        end
        check("R5 flag ignores divider", n, 0);
        lock_mode = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule